// File: doc/BRIEF.md
# Stallable Snapshot Tick Counter

This block is the time base of a system timer: a wide up-counter that advances by one on every cycle in which the count-clock enable pulse is high. At the nominal rate there are 16 such pulses per microsecond. Counting can be stopped in two ways. A run bit stops it outright. A per-core stall selection stops it while a selected processor reports that it is halted.

Software places a new count in two staged words, a high part and a low part. The new count takes effect only when a separate commit strobe is given. Software never reads the live count directly. It raises a snapshot request, which copies the count into a holding register and lowers the valid flag. The flag rises again one cycle later. The high and low snapshot words therefore always come from the same count value.

Top module: `tick_snap_counter`

## Requirements
- R1: After the synchronous reset the count and the snapshot are zero, `snap_valid` is low, counting is enabled and no core's stall is selected.
- R2: The count advances by exactly one on each clock edge where `tick_en` is high and counting is permitted. Without `tick_en` it holds.
- R3: The count is 52 bits wide. It carries from the low word into the high word, and it wraps from 2^52-1 to zero. `snap_hi` bits 31:20 always read zero.
- R4: `ld_hi_wr` stages `wr_data[19:0]` as the high part, and bits 31:20 are discarded. `ld_lo_wr` stages `wr_data` as the low word. Staging alone does not change the count.
- R5: On a `ld_commit` edge the count becomes the staged value. If counting is permitted, it then continues upward from that value.
- R6: When `ld_commit` and a permitted tick fall on the same edge, the loaded value wins and that tick is not added.
- R7: On a `snap_req` edge the snapshot takes the count as it stood in that request cycle, and `snap_valid` goes low. `snap_valid` is high again from the following edge onward.
- R8: Between requests, `snap_hi`, `snap_lo` and `snap_valid` hold their values while the count keeps moving.
- R9: A `cfg_wr` with `cfg_run_en` = 0 stops all counting, and a later write with 1 resumes it.
- R10: `cfg_stall_sel` bit i (bit 0 for core 0, bit 1 for core 1) freezes counting while `core_halt` bit i is high. A halt on a core that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-clock enable pulse |
| core_halt | input | 2 | Halt indication, one bit per core |
| cfg_wr | input | 1 | Write strobe for the run bit and the stall selection |
| cfg_run_en | input | 1 | Run bit value |
| cfg_stall_sel | input | 2 | Stall selection, one bit per core |
| wr_data | input | 32 | Data for the staged words |
| ld_hi_wr | input | 1 | Stage the high part |
| ld_lo_wr | input | 1 | Stage the low word |
| ld_commit | input | 1 | Copy the staged value into the count |
| snap_req | input | 1 | Request a snapshot |
| snap_valid | output | 1 | Snapshot is ready |
| snap_hi | output | 32 | Snapshot bits 51:32, zero-extended |
| snap_lo | output | 32 | Snapshot bits 31:0 |

## Verification
Some rules can be checked on every cycle, and assertions cover those:
- a committed load wins over a tick;
- the count holds when it may not advance;
- the count steps by exactly one when it may advance;
- the count stays frozen while a selected core is halted;
- the snapshot stays stable between requests;
- the valid flag drops after a request.

Other behaviour can only be shown by the directed scenarios, because it depends on a specific sequence of values:
- the exact values read after a load or a number of ticks;
- masking of the high staged word;
- the carry into the high word and the wrap at 2^52;
- staging that is never committed;
- the flag rising again one cycle after the request.

// File: rtl/tick_snap_pkg.sv
package tick_snap_pkg;
  localparam int unsigned CNT_W_DEF  = 52;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned CORES_DEF  = 2;

  typedef enum logic [1:0] {
    ADV_HOLD  = 2'd0,
    ADV_STEP  = 2'd1,
    ADV_LOAD  = 2'd2
  } adv_e;
endpackage

// File: rtl/tsc_gate.sv
module tsc_gate #(
  parameter int unsigned CORES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_run_en,
  input  logic [CORES-1:0] cfg_stall_sel,
  input  logic [CORES-1:0] core_halt,
  input  logic             tick_en,
  output logic             run_q,
  output logic [CORES-1:0] stall_sel_q,
  output logic             advance
);
  logic [CORES-1:0] frozen_by;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b1;
      stall_sel_q <= '0;
    end else if (cfg_wr) begin
      run_q       <= cfg_run_en;
      stall_sel_q <= cfg_stall_sel;
    end
  end

  for (genvar c = 0; c < CORES; c++) begin : g_core
    assign frozen_by[c] = stall_sel_q[c] & core_halt[c];
  end

  always_comb advance = tick_en & run_q & ~(|frozen_by);
endmodule

// File: rtl/tsc_core.sv
module tsc_core
  import tick_snap_pkg::*;
#(
  parameter int unsigned CNT_W  = 52,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ld_hi_wr,
  input  logic              ld_lo_wr,
  input  logic              ld_commit,
  input  logic              advance,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam int unsigned HI_W = CNT_W - WORD_W;

  logic [HI_W-1:0]   stage_hi;
  logic [WORD_W-1:0] stage_lo;
  logic [CNT_W-1:0]  load_val;
  adv_e              act;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi <= '0;
      stage_lo <= '0;
    end else begin
      if (ld_hi_wr) stage_hi <= wr_data[HI_W-1:0];
      if (ld_lo_wr) stage_lo <= wr_data;
    end
  end

  always_comb begin
    load_val = {stage_hi, stage_lo};
    if (ld_commit)    act = ADV_LOAD;
    else if (advance) act = ADV_STEP;
    else              act = ADV_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case (act)
        ADV_LOAD: cnt_q <= load_val;
        ADV_STEP: cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: the load wins even when a tick arrives on the same edge
  a_r6_commit_wins: assert property (@(posedge clk) disable iff (rst)
    ld_commit |=> cnt_q == $past({stage_hi, stage_lo}));
  // R2: the count does not move without a permitted tick
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld_commit && !advance) |=> $stable(cnt_q));
  // R2 and R3: a permitted tick adds exactly one, wrapping at the width
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!ld_commit && advance) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/tsc_snap.sv
module tsc_snap #(
  parameter int unsigned CNT_W  = 52,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap_req,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic              snap_valid,
  output logic [WORD_W-1:0] snap_hi,
  output logic [WORD_W-1:0] snap_lo
);
  localparam int unsigned HI_W  = CNT_W - WORD_W;
  localparam int unsigned PAD_W = WORD_W - HI_W;

  logic [CNT_W-1:0] held;
  logic             pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      pending    <= 1'b0;
      snap_valid <= 1'b0;
    end else begin
      pending <= snap_req;
      if (snap_req) begin
        held       <= cnt_q;
        snap_valid <= 1'b0;
      end else if (pending) begin
        snap_valid <= 1'b1;
      end
    end
  end

  assign snap_hi = {{PAD_W{1'b0}}, held[CNT_W-1:WORD_W]};
  assign snap_lo = held[WORD_W-1:0];

  // R8: the snapshot does not change without a request
  a_r8_snap_stable: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(held));
  // R7: the flag is low right after a request
  a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> !snap_valid);
  // R7: the snapshot equals the count seen in the request cycle
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> held == $past(cnt_q));
endmodule

// File: rtl/tick_snap_counter.sv
module tick_snap_counter
  import tick_snap_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CORES  = CORES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CORES-1:0]  core_halt,
  input  logic              cfg_wr,
  input  logic              cfg_run_en,
  input  logic [CORES-1:0]  cfg_stall_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ld_hi_wr,
  input  logic              ld_lo_wr,
  input  logic              ld_commit,
  input  logic              snap_req,
  output logic              snap_valid,
  output logic [WORD_W-1:0] snap_hi,
  output logic [WORD_W-1:0] snap_lo
);
  logic             run_q;
  logic [CORES-1:0] stall_sel_q;
  logic             advance;
  logic [CNT_W-1:0] cnt_q;

  tsc_gate #(.CORES(CORES)) gate_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_run_en(cfg_run_en),
    .cfg_stall_sel(cfg_stall_sel), .core_halt(core_halt), .tick_en(tick_en),
    .run_q(run_q), .stall_sel_q(stall_sel_q), .advance(advance)
  );

  tsc_core #(.CNT_W(CNT_W), .WORD_W(WORD_W)) core_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .ld_hi_wr(ld_hi_wr),
    .ld_lo_wr(ld_lo_wr), .ld_commit(ld_commit), .advance(advance),
    .cnt_q(cnt_q)
  );

  tsc_snap #(.CNT_W(CNT_W), .WORD_W(WORD_W)) snap_i (
    .clk(clk), .rst(rst), .snap_req(snap_req), .cnt_q(cnt_q),
    .snap_valid(snap_valid), .snap_hi(snap_hi), .snap_lo(snap_lo)
  );

  // R10: a halted, selected core freezes the count
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ld_commit && |(stall_sel_q & core_halt)) |=> $stable(cnt_q));
  // R9: with the run bit clear, only a load can change the count
  a_r9_stopped: assert property (@(posedge clk) disable iff (rst)
    (!ld_commit && !run_q) |=> $stable(cnt_q));
endmodule

// File: tb/tick_snap_counter_tb_top.sv
`timescale 1ns/1ps
module tick_snap_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 0, cfg_wr = 0, cfg_run_en = 1;
  logic [1:0]  core_halt = 0, cfg_stall_sel = 0;
  logic [31:0] wr_data = 0;
  logic        ld_hi_wr = 0, ld_lo_wr = 0, ld_commit = 0, snap_req = 0;
  logic        snap_valid;
  logic [31:0] snap_hi, snap_lo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_snap_counter dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .core_halt(core_halt),
    .cfg_wr(cfg_wr), .cfg_run_en(cfg_run_en), .cfg_stall_sel(cfg_stall_sel),
    .wr_data(wr_data), .ld_hi_wr(ld_hi_wr), .ld_lo_wr(ld_lo_wr),
    .ld_commit(ld_commit), .snap_req(snap_req), .snap_valid(snap_valid),
    .snap_hi(snap_hi), .snap_lo(snap_lo)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk) tick_en = 1;
      repeat (n) @(negedge clk);
      tick_en = 0;
    end
  endtask

  task automatic stage(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk) begin wr_data = hi; ld_hi_wr = 1; end
    @(negedge clk) begin ld_hi_wr = 0; wr_data = lo; ld_lo_wr = 1; end
    @(negedge clk) ld_lo_wr = 0;
  endtask

  task automatic commit();
    @(negedge clk) ld_commit = 1;
    @(negedge clk) ld_commit = 0;
  endtask

  task automatic cfg(input logic run, input logic [1:0] sel);
    @(negedge clk) begin cfg_wr = 1; cfg_run_en = run; cfg_stall_sel = sel; end
    @(negedge clk) cfg_wr = 0;
  endtask

  task automatic read_expect(input logic [63:0] exp, input string tag);
    logic [63:0] got;
    @(negedge clk) snap_req = 1;
    @(negedge clk) snap_req = 0;
    chk(snap_valid == 1'b0, "R7 valid low after request", {63'd0, snap_valid}, 64'd0);
    @(negedge clk);
    chk(snap_valid == 1'b1, "R7 valid high one cycle later", {63'd0, snap_valid}, 64'd1);
    got = {snap_hi, snap_lo};
    chk(got == exp, tag, got, exp);
  endtask

  task automatic t_reset();
    chk(snap_valid == 0 && snap_hi == 0 && snap_lo == 0, "R1 reset outputs",
        {snap_hi, snap_lo}, 64'd0);
    read_expect(64'd0, "R1 count zero after reset");
    core_halt = 2'b11;
    ticks(5);
    core_halt = 2'b00;
    read_expect(64'd5, "R1 run on, stalls off after reset (R2 five ticks)");
  endtask

  task automatic t_stage_mask();
    stage(32'hFFFF_FFFF, 32'h1234_5678);
    read_expect(64'd5, "R4 staging alone leaves count");
    commit();
    read_expect({32'h000F_FFFF, 32'h1234_5678}, "R4 high part masked to 20 bits");
  endtask

  task automatic t_continue();
    stage(32'h0000_0000, 32'h0000_0100);
    commit();
    ticks(3);
    read_expect(64'h103, "R5 counting continues from loaded value");
    repeat (4) @(negedge clk);
    read_expect(64'h103, "R2 idle cycles without tick hold");
  endtask

  task automatic t_carry_wrap();
    stage(32'h0, 32'hFFFF_FFFF);
    commit();
    ticks(1);
    read_expect({32'h1, 32'h0}, "R3 carry into high word");
    stage(32'h000F_FFFF, 32'hFFFF_FFFF);
    commit();
    ticks(1);
    read_expect(64'd0, "R3 wrap from 2^52-1 to zero");
  endtask

  task automatic t_priority();
    stage(32'h0, 32'h0000_0A00);
    @(negedge clk) begin ld_commit = 1; tick_en = 1; end
    @(negedge clk) begin ld_commit = 0; tick_en = 0; end
    read_expect(64'hA00, "R6 load beats same-edge tick");
    ticks(2);
    read_expect(64'hA02, "R6 ticks after the load still count");
  endtask

  task automatic t_snap_hold();
    logic [63:0] first;
    read_expect(64'hA02, "R7 capture");
    first = {snap_hi, snap_lo};
    ticks(7);
    chk({snap_hi, snap_lo} == first && snap_valid, "R8 snapshot held while counting",
        {snap_hi, snap_lo}, first);
    read_expect(64'hA09, "R8 new request sees moved count");
  endtask

  task automatic t_run();
    cfg(1'b0, 2'b00);
    ticks(6);
    read_expect(64'hA09, "R9 run bit clear stops counting");
    cfg(1'b1, 2'b00);
    ticks(2);
    read_expect(64'hA0B, "R9 run bit set resumes");
  endtask

  task automatic t_stall();
    cfg(1'b1, 2'b10);
    core_halt = 2'b10;
    ticks(4);
    core_halt = 2'b00;
    read_expect(64'hA0B, "R10 selected core1 halt freezes");
    core_halt = 2'b01;
    ticks(3);
    core_halt = 2'b00;
    read_expect(64'hA0E, "R10 unselected core0 halt ignored");
    cfg(1'b1, 2'b01);
    core_halt = 2'b01;
    ticks(2);
    core_halt = 2'b00;
    ticks(1);
    read_expect(64'hA0F, "R10 core0 selected and halted freezes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_stage_mask();
    t_continue();
    t_carry_wrap();
    t_priority();
    t_snap_hold();
    t_run();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule